// File: doc/BRIEF.md
# Key-Locked Adder and Multiplier Datapath

This block is a small registered arithmetic unit that either adds or multiplies two unsigned operands. Selected internal wires of both arithmetic units run through XOR gates whose second input is a bit of an external key bus. Each gate position also carries a built-in inversion wherever the designated good key holds a 1. A gate therefore passes its wire unchanged only when the key bit equals the matching bit of the good key. The datapath computes the true sum or product only when the whole key bus carries that good pattern. Any other pattern corrupts results for at least some operands.

The adder is a ripple-carry structure. Every one of its propagate wires and every one of its generate wires is key-gated. The multiplier is an array of partial-product AND terms followed by a shifted accumulation, and a fixed scattered set of those terms is key-gated. Which terms are gated and what the good key is are build-time parameters. Because the key stays fixed once the part is activated, a correctly keyed unit behaves exactly like an unlocked one. Test vectors written for the unlocked unit therefore still apply.

Top module: `keyed_arith_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_o` becomes all zeros at that edge.
- R2: A result appears on `res_o` at the first rising edge after the one where the operands, function select and key are sampled. Back-to-back operations each land exactly one cycle after their inputs.
- R3: With `fn_i` = 0 (add) and the good key on `key_i`, `res_o` equals the zero-extended 17-bit sum `a_i + b_i`, with the carry out in bit 16, for every operand pair.
- R4: With `fn_i` = 1 (multiply) and the good key on `key_i`, `res_o` equals the full 32-bit product `a_i * b_i` for every operand pair.
- R5: The key is split as follows. Bit i (0..15) gates adder propagate bit i, and bit 16+i gates adder generate bit i. Bit 32+k (k = 0..31) gates the partial product formed from `b_i[k mod 16]` and `a_i[(5k + k/16) mod 16]`, which has weight 2^(row+column). The default good key is 64'hA5C3_1E7B_94D2_6F08, and any value can be chosen instead.
- R6: In add mode with `a_i` = `b_i` = 0 and only key bit i (0..15) wrong, `res_o` equals 1 << i.
- R7: In add mode with `a_i` = `b_i` = 0 and only key bit 16+i wrong, `res_o` equals 1 << (i+1), where i = 15 sets the carry bit 16.
- R8: In multiply mode with `a_i` = `b_i` = 0 and only key bit 32+k wrong, `res_o` equals 1 << (row+column) of the term defined in R5.
- R9: Key bits 32..63 have no effect in add mode, and key bits 0..31 have no effect in multiply mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| fn_i | input | 1 | Function select: 0 add, 1 multiply |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| key_i | input | 64 | Lock key bus |
| res_o | output | 32 | Registered result |

## Verification
Under the good key, both functions are driven with zero operands, with all-ones operands and with operands that carry across every bit, and also with random pairs. These cases tell a correct unit apart from one that drops a carry or a high product bit. Each of the 64 single-bit key errors is then applied with both operands at zero. Since the clean result is zero, the exact power of two that appears shows which gate the wrong bit reached and that its inverted wire lands on the weight it should. Random operands with the unused half of the key flipped show that the two halves of the key are independent, and a back-to-back burst pins the one-cycle latency.

// File: rtl/kac_pkg.sv
package kac_pkg;

    localparam int DATA_W_DEF = 16;
    localparam int STRIDE_DEF = 5;

    typedef enum logic {
        FN_ADD = 1'b0,
        FN_MUL = 1'b1
    } fn_e;

    // row of the k-th gated partial product (multiplier bit index)
    function automatic int lock_row(input int k, input int w);
        return k % w;
    endfunction

    // column of the k-th gated partial product (multiplicand bit index)
    function automatic int lock_col(input int k, input int w, input int s);
        return (k * s + k / w) % w;
    endfunction

    // gate index covering term (r, c), or -1 when the term is not gated
    function automatic int lock_index(input int r, input int c, input int w, input int s);
        int idx;
        idx = -1;
        for (int k = 0; k < 2 * w; k++) begin
            if (lock_row(k, w) == r && lock_col(k, w, s) == c) idx = k;
        end
        return idx;
    endfunction

endpackage

// File: rtl/kac_gate_bank.sv
module kac_gate_bank #(
    parameter int          N    = 16,
    parameter logic [N-1:0] GOOD = '0
) (
    input  logic [N-1:0] raw_i,
    input  logic [N-1:0] key_i,
    output logic [N-1:0] out_o
);
    // one XOR per gated wire, plus a fixed inverter where the good bit is 1
    for (genvar i = 0; i < N; i++) begin : g_gate
        if (GOOD[i]) begin : g_inv
            assign out_o[i] = ~(raw_i[i] ^ key_i[i]);
        end else begin : g_pass
            assign out_o[i] = raw_i[i] ^ key_i[i];
        end
    end
endmodule

// File: rtl/kac_adder.sv
module kac_adder #(
    parameter int              W    = 16,
    parameter logic [2*W-1:0]  GOOD = '0
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [2*W-1:0] key_i,
    output logic [W:0]     sum_o
);
    logic [W-1:0] p_raw, g_raw, p_lk, g_lk, s;
    logic [W:0]   c;

    assign p_raw = a_i ^ b_i;
    assign g_raw = a_i & b_i;

    kac_gate_bank #(.N(W), .GOOD(GOOD[W-1:0])) i_prop_gates (
        .raw_i(p_raw), .key_i(key_i[W-1:0]), .out_o(p_lk)
    );

    kac_gate_bank #(.N(W), .GOOD(GOOD[2*W-1:W])) i_gen_gates (
        .raw_i(g_raw), .key_i(key_i[2*W-1:W]), .out_o(g_lk)
    );

    always_comb begin
        c[0] = 1'b0;
        for (int i = 0; i < W; i++) begin
            s[i]   = p_lk[i] ^ c[i];
            c[i+1] = g_lk[i] | (p_lk[i] & c[i]);
        end
    end

    assign sum_o = {c[W], s};
endmodule

// File: rtl/kac_mult.sv
module kac_mult
    import kac_pkg::*;
#(
    parameter int              W      = 16,
    parameter int              STRIDE = 5,
    parameter logic [2*W-1:0]  GOOD   = '0
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [2*W-1:0] key_i,
    output logic [2*W-1:0] prod_o
);
    localparam int NL = 2 * W;
    localparam int PW = 2 * W;

    logic [W*W-1:0] pp_raw, pp_lk;
    logic [NL-1:0]  sel_raw, sel_lk;

    // plain partial products: index r*W + c is b[r] & a[c]
    for (genvar r = 0; r < W; r++) begin : g_row
        for (genvar cc = 0; cc < W; cc++) begin : g_col
            assign pp_raw[r*W+cc] = b_i[r] & a_i[cc];
        end
    end

    // gather the gated terms
    for (genvar k = 0; k < NL; k++) begin : g_gather
        assign sel_raw[k] = pp_raw[lock_row(k, W) * W + lock_col(k, W, STRIDE)];
    end

    kac_gate_bank #(.N(NL), .GOOD(GOOD)) i_pp_gates (
        .raw_i(sel_raw), .key_i(key_i), .out_o(sel_lk)
    );

    // scatter them back over the array
    for (genvar r = 0; r < W; r++) begin : g_srow
        for (genvar cc = 0; cc < W; cc++) begin : g_scol
            localparam int LI = lock_index(r, cc, W, STRIDE);
            if (LI >= 0) begin : g_locked
                assign pp_lk[r*W+cc] = sel_lk[LI];
            end else begin : g_open
                assign pp_lk[r*W+cc] = pp_raw[r*W+cc];
            end
        end
    end

    always_comb begin
        prod_o = '0;
        for (int r = 0; r < W; r++) begin
            prod_o = prod_o + (PW'(pp_lk[r*W +: W]) << r);
        end
    end
endmodule

// File: rtl/keyed_arith_core.sv
module keyed_arith_core
    import kac_pkg::*;
#(
    parameter int                     DATA_W   = DATA_W_DEF,
    parameter int                     STRIDE   = STRIDE_DEF,
    parameter logic [4*DATA_W-1:0]    GOOD_KEY = 64'hA5C3_1E7B_94D2_6F08
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fn_i,
    input  logic [DATA_W-1:0]     a_i,
    input  logic [DATA_W-1:0]     b_i,
    input  logic [4*DATA_W-1:0]   key_i,
    output logic [2*DATA_W-1:0]   res_o
);
    localparam int W   = DATA_W;
    localparam int PW  = 2 * DATA_W;
    localparam int HK  = 2 * DATA_W;

    fn_e          fn;
    logic [W:0]   add_sum;
    logic [PW-1:0] mul_prod;

    assign fn = fn_e'(fn_i);

    kac_adder #(.W(W), .GOOD(GOOD_KEY[HK-1:0])) i_adder (
        .a_i(a_i), .b_i(b_i), .key_i(key_i[HK-1:0]), .sum_o(add_sum)
    );

    kac_mult #(.W(W), .STRIDE(STRIDE), .GOOD(GOOD_KEY[2*HK-1:HK])) i_mult (
        .a_i(a_i), .b_i(b_i), .key_i(key_i[2*HK-1:HK]), .prod_o(mul_prod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o <= '0;
        end else if (fn == FN_MUL) begin
            res_o <= mul_prod;
        end else begin
            res_o <= PW'(add_sum);
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> res_o == '0);

    // R3
    add_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (key_i[HK-1:0] == GOOD_KEY[HK-1:0]) |-> add_sum == ({1'b0, a_i} + {1'b0, b_i}));

    // R4
    mul_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (key_i[2*HK-1:HK] == GOOD_KEY[2*HK-1:HK]) |-> mul_prod == (PW'(a_i) * PW'(b_i)));

    // R2
    add_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (!fn_i && key_i == GOOD_KEY) |=> res_o == $past(PW'({1'b0, a_i} + {1'b0, b_i})));

    // R2
    mul_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (fn_i && key_i == GOOD_KEY) |=> res_o == $past(PW'(a_i) * PW'(b_i)));
endmodule

// File: tb/test_keyed_arith_core.sv
module test_keyed_arith_core;
    localparam int          CLK_PERIOD = 10;
    localparam int          W    = 16;
    localparam int          PW   = 32;
    localparam logic [63:0] GOOD = 64'hA5C3_1E7B_94D2_6F08;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fn_i = 1'b0;
    logic [W-1:0]  a_i = 16'h1234;
    logic [W-1:0]  b_i = 16'h4321;
    logic [63:0]   key_i = 64'h0;
    logic [PW-1:0] res_o;

    logic [PW-1:0] exp_q[$];
    string         tag_q[$];
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            mon_on = 1'b0;

    keyed_arith_core i_keyed_arith_core (
        .clk(clk), .rst(rst), .fn_i(fn_i), .a_i(a_i), .b_i(b_i),
        .key_i(key_i), .res_o(res_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic [PW-1:0] got, input logic [PW-1:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [PW-1:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b);
        return {16'h0, a} + {16'h0, b};
    endfunction

    function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        return {16'h0, a} * {16'h0, b};
    endfunction

    task automatic drive(input logic fn, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [63:0] key, input logic [PW-1:0] exp, input string tag);
        @(negedge clk);
        fn_i = fn; a_i = a; b_i = b; key_i = key;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // monitor: one result per cycle, one edge after the inputs were driven
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on && exp_q.size() > 0) begin
                chk(res_o, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] ra, rb;
        // R1: reset clears the result register
        repeat (3) @(posedge clk);
        #1 chk(res_o, '0, "R1 reset");
        @(negedge clk);
        rst = 1'b0;
        mon_on = 1'b1;

        // R3 / R5: add under the good key
        drive(1'b0, 16'h0000, 16'h0000, GOOD, ref_add(16'h0000, 16'h0000), "R3 zero");
        drive(1'b0, 16'hFFFF, 16'h0001, GOOD, 32'h0001_0000, "R3 carry ripple");
        drive(1'b0, 16'hFFFF, 16'hFFFF, GOOD, 32'h0001_FFFE, "R3 all ones");
        drive(1'b0, 16'h5555, 16'hAAAA, GOOD, 32'h0000_FFFF, "R3 alternating");
        for (int n = 0; n < 24; n++) begin
            ra = W'($urandom); rb = W'($urandom);
            drive(1'b0, ra, rb, GOOD, ref_add(ra, rb), "R3 random R5");
        end

        // R4 / R5: multiply under the good key
        drive(1'b1, 16'h0000, 16'hBEEF, GOOD, 32'h0, "R4 zero");
        drive(1'b1, 16'hFFFF, 16'hFFFF, GOOD, 32'hFFFE_0001, "R4 all ones");
        drive(1'b1, 16'h8000, 16'h8000, GOOD, 32'h4000_0000, "R4 top bits");
        drive(1'b1, 16'h0001, 16'hC3A5, GOOD, 32'h0000_C3A5, "R4 unit");
        for (int n = 0; n < 24; n++) begin
            ra = W'($urandom); rb = W'($urandom);
            drive(1'b1, ra, rb, GOOD, ref_mul(ra, rb), "R4 random R5");
        end

        // R2: back-to-back alternating functions
        drive(1'b0, 16'h00FF, 16'h0F01, GOOD, 32'h0000_1000, "R2 burst add");
        drive(1'b1, 16'h0100, 16'h0100, GOOD, 32'h0001_0000, "R2 burst mul");
        drive(1'b0, 16'h8000, 16'h8000, GOOD, 32'h0001_0000, "R2 burst add carry");
        drive(1'b1, 16'h0003, 16'h0005, GOOD, 32'h0000_000F, "R2 burst mul small");

        // R6: single wrong propagate key bit
        for (int i = 0; i < 16; i++) begin
            drive(1'b0, 16'h0, 16'h0, GOOD ^ (64'h1 << i), PW'(1) << i, "R6 prop key");
        end
        // R7: single wrong generate key bit
        for (int i = 0; i < 16; i++) begin
            drive(1'b0, 16'h0, 16'h0, GOOD ^ (64'h1 << (16 + i)), PW'(1) << (i + 1), "R7 gen key");
        end
        // R8 / R5: single wrong partial-product key bit
        for (int k = 0; k < 32; k++) begin
            int row, col;
            row = k % 16;
            col = (5 * k + k / 16) % 16;
            drive(1'b1, 16'h0, 16'h0, GOOD ^ (64'h1 << (32 + k)), PW'(1) << (row + col), "R8 pp key R5");
        end

        // R9: the other unit's key half has no effect
        for (int n = 0; n < 8; n++) begin
            ra = W'($urandom); rb = W'($urandom);
            drive(1'b0, ra, rb, GOOD ^ 64'hFFFF_FFFF_0000_0000, ref_add(ra, rb), "R9 add ignores mul key");
            drive(1'b1, ra, rb, GOOD ^ 64'h0000_0000_FFFF_FFFF, ref_mul(ra, rb), "R9 mul ignores add key");
        end

        drain();

        // R1: reset in mid-run clears a nonzero result
        drive(1'b1, 16'h1234, 16'h5678, GOOD, ref_mul(16'h1234, 16'h5678), "R4 before reset");
        drain();
        mon_on = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #1 chk(res_o, '0, "R1 mid-run reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule